// File: doc/BRIEF.md
# Programmable-Format UART Frame Engine

This block pairs an asynchronous serial transmitter with a receiver. Both share one five-bit format word that selects how many data bits a character carries, how long the stop period lasts and whether a parity bit is present and of which sense. A host writes the format word through a one-cycle write strobe. Each side copies the format word when it begins a character, so a write made during a character takes effect from the next character onward.

The transmitter accepts a byte through a valid/ready handshake. It then drives a low start bit, the data bits least significant first, an optional parity bit and a high stop period. The receiver watches a synchronised copy of the serial input. It confirms a start bit at its midpoint, samples every later bit at its midpoint and then presents the character for one cycle with parity-error and framing-error flags. A free-running tick input at sixteen times the baud rate times both directions, and one bit lasts sixteen ticks.

Top module: `uart_frame_engine`

## Requirements
- R1: Format bits [1:0] select 5, 6, 7 or 8 data bits for the codes 00, 01, 10 and 11. The transmitter sends a low start bit and then the data least significant bit first, and every bit lasts 16 ticks.
- R2: With format bit [2] at 0 the stop period is one high bit of 16 ticks, whatever the word length.
- R3: With format bit [2] at 1 and a 5-bit word, the high stop period lasts 24 ticks.
- R4: With format bit [2] at 1 and a 6-, 7- or 8-bit word, the high stop period lasts 32 ticks.
- R5: With format bit [3] at 0 no parity bit is sent, none is expected, and the parity-error flag stays 0.
- R6: With format bit [3] at 1 a parity bit follows the data. Format bit [4] at 0 makes the count of ones in data plus parity odd, and at 1 makes it even. The receiver raises rx_perr_o when the received parity bit breaks that rule.
- R7: tx_ready_o is high only while the transmitter is idle, and txd_o is then high. A byte is taken when tx_valid_i and tx_ready_o are both high, and tx_ready_o stays low until the stop period ends.
- R8: The receiver checks a low line at the 8th tick after the falling edge. If the line is high at that point, it discards the start and produces no character.
- R9: If the line is low at the midpoint of the first stop bit, rx_ferr_o is raised together with the character. The receiver then waits for a high line before it accepts a new start bit.
- R10: For words shorter than 8 bits, the unused upper bits of rx_data_o are 0.
- R11: Both sides copy the format word at the start of each character. A format write during a character leaves that character unchanged and applies to the next one.
- R12: Each received character is reported by a single-cycle rx_valid_o pulse that carries the data and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the baud rate |
| cfg_we_i | input | 1 | Write strobe for the format word |
| cfg_wdata_i | input | 5 | Format word: [4] parity type, [3] parity enable, [2] stop select, [1:0] word length |
| tx_valid_i | input | 1 | Byte to send is valid |
| tx_data_i | input | 8 | Byte to send |
| tx_ready_o | output | 1 | Transmitter idle and able to take a byte |
| txd_o | output | 1 | Serial output, idle high |
| rxd_i | input | 1 | Serial input, asynchronous |
| rx_valid_o | output | 1 | One-cycle pulse: received character present |
| rx_data_o | output | 8 | Received character, zero-extended |
| rx_perr_o | output | 1 | Parity error on this character |
| rx_ferr_o | output | 1 | Stop bit read low on this character |

## Verification
The assertions check invariants on every cycle. They confirm that an idle transmitter holds the line high, that an accepted byte drops ready and starts the start bit on the next cycle, and that the stop period is always high. On the receive side they confirm that a valid pulse lasts one cycle, that the upper data bits are clear for short words and that no parity error appears while parity is off. Other behaviour depends on timing across a whole character, and only the bench scenarios show it. This covers the bit order and bit values on the line, the 16-, 24- and 32-tick stop lengths, glitch rejection, the detection of parity and framing errors, and a format write that lands in the middle of a character.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;
  localparam int DW = 8;
  localparam int BW = $clog2(DW + 1);

  // field order matches format word bits [4:0]
  typedef struct packed {
    logic       par_type;  // 1 = even
    logic       par_en;
    logic       stop_sel;
    logic [1:0] wlen;
  } fmt_t;

  function automatic logic [BW-1:0] data_bits(fmt_t f);
    return BW'(DW - 3) + BW'(f.wlen);
  endfunction

  function automatic logic [DW-1:0] len_mask(logic [BW-1:0] n);
    return {DW{1'b1}} >> (BW'(DW) - n);
  endfunction

  function automatic logic par_bit(logic [DW-1:0] d, logic [BW-1:0] n, logic even);
    return (^(d & len_mask(n))) ^ ~even;
  endfunction
endpackage

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_fmt_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  fmt_t          fmt_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          ready_o,
  output logic          txd_o
);
  localparam int CW = $clog2(2 * OVS + 1);
  localparam logic [CW-1:0] LEN_BIT  = CW'(OVS);
  localparam logic [CW-1:0] LEN_1P5  = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] LEN_TWO  = CW'(2 * OVS);

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;

  tx_st_e        state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  fmt_t          fmt_q;
  logic          par_q;
  logic          txd_q;

  logic [CW-1:0] stop_len, cur_len;
  logic [BW-1:0] nbits;
  logic          bit_end;

  always_comb begin
    if (!fmt_q.stop_sel)         stop_len = LEN_BIT;
    else if (fmt_q.wlen == 2'b00) stop_len = LEN_1P5;
    else                         stop_len = LEN_TWO;
    cur_len = (state_q == TX_STOP) ? stop_len : LEN_BIT;
    nbits   = data_bits(fmt_q);
    bit_end = tick_i && (cnt_q == cur_len - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
    end else if (state_q == TX_IDLE) begin
      if (valid_i) begin
        sh_q    <= data_i;
        fmt_q   <= fmt_i;
        par_q   <= par_bit(data_i, data_bits(fmt_i), fmt_i.par_type);
        cnt_q   <= '0;
        txd_q   <= 1'b0;
        state_q <= TX_START;
      end
    end else if (tick_i) begin
      if (bit_end) begin
        cnt_q <= '0;
        unique case (state_q)
          TX_START: begin
            txd_q   <= sh_q[0];
            sh_q    <= sh_q >> 1;
            bit_q   <= BW'(1);
            state_q <= TX_DATA;
          end
          TX_DATA: begin
            if (bit_q == nbits) begin
              txd_q   <= fmt_q.par_en ? par_q : 1'b1;
              state_q <= fmt_q.par_en ? TX_PAR : TX_STOP;
            end else begin
              txd_q <= sh_q[0];
              sh_q  <= sh_q >> 1;
              bit_q <= bit_q + 1'b1;
            end
          end
          TX_PAR: begin
            txd_q   <= 1'b1;
            state_q <= TX_STOP;
          end
          default: state_q <= TX_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o = (state_q == TX_IDLE);
  assign txd_o   = txd_q;

  a_r7_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> txd_o);
  a_r7_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!ready_o && !txd_o));
  a_r2_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_STOP) |-> txd_o);
  a_r1_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < cur_len);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_fmt_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  fmt_t          fmt_i,
  input  logic          rxd_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

  rx_st_e        state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  fmt_t          fmt_q;
  logic          par_rx_q;
  logic          armed_q;
  logic          valid_q, perr_q, ferr_q;
  logic [DW-1:0] data_q;

  logic [BW-1:0] nbits;
  logic [DW-1:0] aligned;
  logic          mid;

  always_comb begin
    nbits   = data_bits(fmt_q);
    aligned = sh_q >> (BW'(DW) - nbits);
    mid     = tick_i && (cnt_q == FULL_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      fmt_q    <= '0;
      par_rx_q <= 1'b0;
      armed_q  <= 1'b0;
      valid_q  <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (rxd_i) armed_q <= 1'b1;
          else if (armed_q) begin
            armed_q <= 1'b0;
            fmt_q   <= fmt_i;
            cnt_q   <= '0;
            state_q <= RX_START;
          end
        end
        RX_START: if (tick_i) begin
          if (cnt_q == HALF_LAST) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= rxd_i ? RX_IDLE : RX_DATA;  // high at mid: glitch
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (mid) begin
            sh_q  <= {rxd_i, sh_q[DW-1:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == nbits - 1'b1)
              state_q <= fmt_q.par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (mid) begin
            par_rx_q <= rxd_i;
            state_q  <= RX_STOP;
          end
        end
        default: if (tick_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (mid) begin
            valid_q <= 1'b1;
            data_q  <= aligned;
            perr_q  <= fmt_q.par_en && (par_rx_q != par_bit(aligned, nbits, fmt_q.par_type));
            ferr_q  <= !rxd_i;
            state_q <= RX_IDLE;
          end
        end
      endcase
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;

  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o & ~len_mask(nbits)) == '0));
  a_r5_no_perr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fmt_q.par_en) |-> !perr_o);
  a_r9_rearm_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE && !armed_q) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fmt_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          cfg_we_i,
  input  logic [4:0]    cfg_wdata_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_ready_o,
  output logic          txd_o,
  input  logic          rxd_i,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_perr_o,
  output logic          rx_ferr_o
);
  localparam fmt_t FMT_RESET = '{par_type: 1'b0, par_en: 1'b0, stop_sel: 1'b0, wlen: 2'b11};

  fmt_t cfg_q;
  logic rxd_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= FMT_RESET;
    else if (cfg_we_i) cfg_q <= fmt_t'(cfg_wdata_i);
  end

  uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_tx_core #(.OVS(OVS)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .fmt_i  (cfg_q),
    .valid_i(tx_valid_i),
    .data_i (tx_data_i),
    .ready_o(tx_ready_o),
    .txd_o  (txd_o)
  );

  uart_rx_core #(.OVS(OVS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .fmt_i  (cfg_q),
    .rxd_i  (rxd_s),
    .valid_o(rx_valid_o),
    .data_o (rx_data_o),
    .perr_o (rx_perr_o),
    .ferr_o (rx_ferr_o)
  );
endmodule

// File: tb/uart_frame_engine_bench.sv
module uart_frame_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D   = 4;   // clocks per baud tick
  localparam int BT  = 16 * D;  // clocks per bit
  localparam int NV  = 10;

  // {cfg[4:0], data[7:0]}
  localparam logic [12:0] VEC [NV] = '{
    {5'b00011, 8'hA5}, {5'b00000, 8'hFF}, {5'b00100, 8'h15}, {5'b00101, 8'h2A},
    {5'b01010, 8'h55}, {5'b11011, 8'h3C}, {5'b11110, 8'h7F}, {5'b01111, 8'h00},
    {5'b11100, 8'h0B}, {5'b01001, 8'h21}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wd = '0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, txd;
  logic       use_drv = 1'b0;
  logic       drv_line = 1'b1;
  logic       rxd;
  logic       rx_valid, rx_perr, rx_ferr;
  logic [7:0] rx_data;

  int n_tests = 0, n_fail = 0, cyc = 0, rx_n = 0, tdiv = 0;
  logic [7:0] cap_d = '0;
  logic       cap_p = 1'b0, cap_f = 1'b0;

  assign rxd = use_drv ? drv_line : txd;

  uart_frame_engine u_uart_frame_engine (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready), .txd_o(txd),
    .rxd_i(rxd), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_perr_o(rx_perr), .rx_ferr_o(rx_ferr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    tdiv <= (tdiv == D - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == D - 1);
    if (rx_valid) begin
      rx_n  <= rx_n + 1;
      cap_d <= rx_data;
      cap_p <= rx_perr;
      cap_f <= rx_ferr;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(logic [4:0] c);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = c;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  function automatic int nb(logic [4:0] c); return 5 + int'(c[1:0]); endfunction
  function automatic int stop_t(logic [4:0] c);
    if (!c[2]) return 16;
    return (c[1:0] == 2'b00) ? 24 : 32;
  endfunction
  function automatic logic [7:0] msk(logic [4:0] c); return 8'hFF >> (8 - nb(c)); endfunction
  function automatic logic pbit(logic [4:0] c, logic [7:0] d);
    logic x = ^(d & msk(c));
    return c[4] ? x : ~x;  // even: total ones even
  endfunction

  // transmit in loopback, check line bits, duration and received result
  task automatic tx_frame(logic [4:0] c, logic [7:0] d, bit chg, logic [4:0] newc);
    int rx0, t0, dur, tot;
    string sreq;
    rx0 = rx_n;
    tot = 16 * (1 + nb(c) + int'(c[3])) + stop_t(c);
    sreq = (stop_t(c) == 16) ? "R2" : ((stop_t(c) == 24) ? "R3" : "R4");
    @(negedge clk);
    chk("R7 ready idle", int'(tx_ready), 1);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
    while (txd) @(negedge clk);
    t0 = cyc;
    wait_clk(BT / 2);
    chk("R1 start low", int'(txd), 0);
    chk("R7 busy", int'(tx_ready), 0);
    if (chg) set_cfg(newc);
    for (int i = 0; i < nb(c); i++) begin
      wait_clk(BT);
      chk("R1 data bit", int'(txd), int'(d[i]));
    end
    if (c[3]) begin
      wait_clk(BT);
      chk("R6 parity bit", int'(txd), int'(pbit(c, d)));
    end
    wait_clk(BT);
    chk({sreq, " stop high"}, int'(txd), 1);
    chk("R7 busy in stop", int'(tx_ready), 0);
    while (!tx_ready) @(negedge clk);
    dur = cyc - t0;
    chk_rng({sreq, " frame length"}, dur, (tot - 1) * D, tot * D + 2);
    wait_clk(4);
    chk("R12 one char", rx_n - rx0, 1);
    chk("R10 rx data", int'(cap_d), int'(d & msk(c)));
    chk("R5 R6 perr", int'(cap_p), 0);
    chk("R9 ferr", int'(cap_f), 0);
  endtask

  task automatic drv_frame(int n, logic [7:0] d, bit pe, logic p, logic stop_lvl);
    use_drv = 1'b1;
    @(negedge clk); drv_line = 1'b0; wait_clk(BT);
    for (int i = 0; i < n; i++) begin
      drv_line = d[i]; wait_clk(BT);
    end
    if (pe) begin drv_line = p; wait_clk(BT); end
    drv_line = stop_lvl; wait_clk(BT);
    drv_line = 1'b1; wait_clk(2 * BT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rx0;
    wait_clk(5);
    chk("R7 reset ready", int'(tx_ready), 1);
    chk("R7 reset line", int'(txd), 1);
    chk("R12 reset valid", int'(rx_valid), 0);
    rst_n = 1'b1;
    wait_clk(5);

    for (int k = 0; k < NV; k++) begin
      set_cfg(VEC[k][12:8]);
      tx_frame(VEC[k][12:8], VEC[k][7:0], 1'b0, 5'b0);
    end

    // R11: format write during a character
    set_cfg(5'b00011);
    tx_frame(5'b00011, 8'hC3, 1'b1, 5'b00100);
    tx_frame(5'b00100, 8'hFF, 1'b0, 5'b0);

    // R6: even parity, wrong bit
    set_cfg(5'b11011);
    rx0 = rx_n;
    drv_frame(8, 8'h3C, 1'b1, 1'b1, 1'b1);
    chk("R6 perr even", int'(cap_p), 1);
    chk("R6 data", int'(cap_d), 8'h3C);
    chk("R12 count", rx_n - rx0, 1);
    // R6: odd parity, correct bit
    set_cfg(5'b01011);
    drv_frame(8, 8'h3C, 1'b1, 1'b1, 1'b1);
    chk("R6 odd ok", int'(cap_p), 0);
    // R5: no parity bit
    set_cfg(5'b00010);
    drv_frame(7, 8'h41, 1'b0, 1'b0, 1'b1);
    chk("R5 perr off", int'(cap_p), 0);
    chk("R5 data", int'(cap_d), 8'h41);

    // R9: low stop bit
    set_cfg(5'b00011);
    rx0 = rx_n;
    drv_frame(8, 8'h5A, 1'b0, 1'b0, 1'b0);
    chk("R9 ferr", int'(cap_f), 1);
    chk("R9 data", int'(cap_d), 8'h5A);
    chk("R9 one char", rx_n - rx0, 1);

    // R8: short low pulse
    rx0 = rx_n;
    @(negedge clk); drv_line = 1'b0; wait_clk(4 * D);
    drv_line = 1'b1; wait_clk(40 * D);
    chk("R8 glitch ignored", rx_n - rx0, 0);
    drv_frame(8, 8'h96, 1'b0, 1'b0, 1'b1);
    chk("R8 next char", int'(cap_d), 8'h96);
    chk("R8 count", rx_n - rx0, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule